// File: doc/BRIEF.md
# Link Bring-Up Speed Sequencer

This block brings a serial link up in a conservative order. A start pulse launches a run. The run limits the link to first-generation speed and enables training. It then waits for the link to report up. After that it can lift the speed cap to second generation. It always requests a directed speed change, waits for that change to settle, and confirms link-up a second time. At the end it reports the negotiated speed. The link partner and the training machinery are outside the block.

The block reaches all of its registers through a single request/acknowledge register port. The registers are the capability register, the speed-control register, the debug status word, the link status word and the receiver override register. Each field update is a read followed by a write, so neighbouring bits keep their values.

Any failure sends the run down a recovery path. The recovery path sets two receiver override enables, holds them for a programmable number of cycles, and clears them again. It then reports done with fail set.

Top module: `link_speed_seq`

## Requirements
- R1: After reset, `done`, `fail`, `train_en` and `bus_req` are low and `speed` is 0.
- R2: A run first reads the capability register (address 0) and writes it back with bits 3:0 set to 1 and every other bit unchanged; `train_en` is still low when that write is accepted.
- R3: The debug status word (address 2) shows the link as up only when bit 4 is 1 and bit 29 (training in progress) is 0. Each wait for link-up issues at most LINK_POLLS reads of that word; if none shows the link up, the run fails.
- R4: When `max_gen` equals 2 at start, the first link-up is followed by a second read-modify-write of the capability register that sets bits 3:0 to 2 and keeps every other bit. Any other `max_gen` value leaves only the single write to 1.
- R5: The speed change is requested by a read-modify-write of the speed-control register (address 1) that sets bit 17 and keeps every other bit. The register is then re-read until bit 17 reads 0. After SC_POLLS reads that all show bit 17 set, the run fails.
- R6: Once the speed change has finished, link-up is awaited again under the rule of R3. On success the link status word (address 3) is read and its bits 19:16 appear on `speed`.
- R7: On failure, the receiver override register (address 4) is read and written back with bits 5 and 3 set. It is left untouched for at least HOLD_CYC cycles, then read again and written back with bits 5 and 3 cleared. The other bits keep their values in both writes.
- R8: `done` is a one-cycle pulse at the end of every run. `fail` is high only together with `done` and only on a failed run. `speed` is 0 after a failed run and holds the read value after a successful one.
- R9: A `start` pulse while a run is in progress has no effect. After `done` the block is idle and accepts a new `start`.
- R10: The register port holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady from the rise of `bus_req` until `bus_ack` is seen, and has at most one access outstanding.
- R11: `train_en` rises when the first capability write completes, stays high through a successful run and is low when a failed run reports done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a run when idle |
| max_gen | input | 2 | Highest generation allowed (2 enables the second cap raise) |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | High with done when the run failed |
| speed | output | 4 | Negotiated speed code from the link status word |
| train_en | output | 1 | Link training enable |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 3 | Register select (0 cap, 1 speed-ctl, 2 debug, 3 link status, 4 rx override) |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access accepted; read data valid in this cycle |
| bus_rdata | input | 32 | Read data |

## Verification
The bench builds the block with LINK_POLLS at 16, SC_POLLS at its working value of 200 and HOLD_CYC at 20. With these values, both timeout paths finish in a few hundred cycles. The bench counts exactly 16 debug reads before a link timeout and exactly 200 speed-control polls before a speed-change timeout. The short hold lets the bench measure the gap between the two override accesses against the parameter. A register model with adjustable link-up delay, training-bit duration, speed-change latency and a link drop after the speed change reaches every exit of the sequence.

// File: rtl/lss_pkg.sv
package lss_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int SPD_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_CAP   = 3'd0,
    RA_SCTL  = 3'd1,
    RA_DBG   = 3'd2,
    RA_LSTAT = 3'd3,
    RA_OVRD  = 3'd4
  } reg_addr_e;

  localparam int DBG_UP_BIT    = 4;
  localparam int DBG_TRAIN_BIT = 29;
  localparam int SC_GO_BIT     = 17;
  localparam int LS_SPD_LSB    = 16;

  localparam logic [DATA_W-1:0] OVRD_MASK = DATA_W'(32'h0000_0028);
  localparam logic [SPD_W-1:0]  GEN1_CODE = 4'd1;
  localparam logic [SPD_W-1:0]  GEN2_CODE = 4'd2;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_CAP1_RD,
    ST_CAP1_WR,
    ST_UP1,
    ST_CAP2_RD,
    ST_CAP2_WR,
    ST_SC_RD,
    ST_SC_WR,
    ST_SC_POLL,
    ST_UP2,
    ST_LS_RD,
    ST_OV_RD,
    ST_OV_SET,
    ST_OV_HOLD,
    ST_OV_RD2,
    ST_OV_CLR,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/lss_bus_port.sv
module lss_bus_port
  import lss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_we,
  input  reg_addr_e         go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic              xfer_done,
  output logic [DATA_W-1:0] xfer_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      xfer_done  <= 1'b0;
      xfer_rdata <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req    <= 1'b0;
          xfer_done  <= 1'b1;
          xfer_rdata <= bus_rdata;
        end
      end else if (go) begin
        bus_req   <= 1'b1;
        bus_we    <= go_we;
        bus_addr  <= go_addr;
        bus_wdata <= go_wdata;
      end
    end
  end

endmodule

// File: rtl/lss_hold_timer.sv
module lss_hold_timer #(
  parameter int HOLD_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int TW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);

  generate
    if (HOLD_CYC == 0) begin : g_none
      logic unused_load;
      assign unused_load = load ^ clk ^ rst;
      assign expired     = 1'b1;
    end else begin : g_count
      logic [TW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= TW'(HOLD_CYC);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
      end
      assign expired = (cnt == '0);
    end
  endgenerate

endmodule

// File: rtl/lss_ctrl_fsm.sv
module lss_ctrl_fsm
  import lss_pkg::*;
#(
  parameter int LINK_POLLS = 1000,
  parameter int SC_POLLS   = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        max_gen,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] xfer_rdata,
  input  logic              hold_expired,
  output logic              go,
  output logic              go_we,
  output reg_addr_e         go_addr,
  output logic [DATA_W-1:0] go_wdata,
  output logic              hold_load,
  output logic              done,
  output logic              fail,
  output logic [SPD_W-1:0]  speed,
  output logic              train_en
);

  localparam int POLL_MAX = (LINK_POLLS > SC_POLLS) ? LINK_POLLS : SC_POLLS;
  localparam int CNT_W    = $clog2(POLL_MAX + 1);
  localparam logic [CNT_W-1:0] LINK_LAST = CNT_W'(LINK_POLLS - 1);
  localparam logic [CNT_W-1:0] SC_LAST   = CNT_W'(SC_POLLS - 1);

  seq_state_e        state;
  logic              pend;
  logic              gen2_q;
  logic              err_q;
  logic [CNT_W-1:0]  poll_cnt;
  logic [DATA_W-1:0] shadow;
  logic              acc_active;
  logic              link_ok;
  logic              sc_busy;

  assign link_ok = xfer_rdata[DBG_UP_BIT] && !xfer_rdata[DBG_TRAIN_BIT];
  assign sc_busy = xfer_rdata[SC_GO_BIT];

  // access decode: which register each state touches and what it writes
  always_comb begin
    acc_active = 1'b1;
    go_we      = 1'b0;
    go_addr    = RA_CAP;
    go_wdata   = shadow;
    case (state)
      ST_CAP1_RD: go_addr = RA_CAP;
      ST_CAP1_WR: begin
        go_we    = 1'b1;
        go_addr  = RA_CAP;
        go_wdata = {shadow[DATA_W-1:SPD_W], GEN1_CODE};
      end
      ST_UP1, ST_UP2: go_addr = RA_DBG;
      ST_CAP2_RD: go_addr = RA_CAP;
      ST_CAP2_WR: begin
        go_we    = 1'b1;
        go_addr  = RA_CAP;
        go_wdata = {shadow[DATA_W-1:SPD_W], GEN2_CODE};
      end
      ST_SC_RD, ST_SC_POLL: go_addr = RA_SCTL;
      ST_SC_WR: begin
        go_we    = 1'b1;
        go_addr  = RA_SCTL;
        go_wdata = shadow | (DATA_W'(1) << SC_GO_BIT);
      end
      ST_LS_RD: go_addr = RA_LSTAT;
      ST_OV_RD, ST_OV_RD2: go_addr = RA_OVRD;
      ST_OV_SET: begin
        go_we    = 1'b1;
        go_addr  = RA_OVRD;
        go_wdata = shadow | OVRD_MASK;
      end
      ST_OV_CLR: begin
        go_we    = 1'b1;
        go_addr  = RA_OVRD;
        go_wdata = shadow & ~OVRD_MASK;
      end
      default: acc_active = 1'b0;
    endcase
  end

  assign go        = acc_active && !pend;
  assign hold_load = (state == ST_OV_SET) && xfer_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pend     <= 1'b0;
      gen2_q   <= 1'b0;
      err_q    <= 1'b0;
      poll_cnt <= '0;
      shadow   <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      speed    <= '0;
      train_en <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (go)        pend <= 1'b1;
      if (xfer_done) pend <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_CAP1_RD;
            gen2_q   <= (max_gen == 2'd2);
            err_q    <= 1'b0;
            speed    <= '0;
            train_en <= 1'b0;
          end
        end
        ST_CAP1_RD: if (xfer_done) begin
          shadow <= xfer_rdata;
          state  <= ST_CAP1_WR;
        end
        ST_CAP1_WR: if (xfer_done) begin
          train_en <= 1'b1;
          poll_cnt <= '0;
          state    <= ST_UP1;
        end
        ST_UP1: if (xfer_done) begin
          if (link_ok) begin
            state <= gen2_q ? ST_CAP2_RD : ST_SC_RD;
          end else if (poll_cnt == LINK_LAST) begin
            err_q    <= 1'b1;
            train_en <= 1'b0;
            state    <= ST_OV_RD;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_CAP2_RD: if (xfer_done) begin
          shadow <= xfer_rdata;
          state  <= ST_CAP2_WR;
        end
        ST_CAP2_WR: if (xfer_done) state <= ST_SC_RD;
        ST_SC_RD: if (xfer_done) begin
          shadow <= xfer_rdata;
          state  <= ST_SC_WR;
        end
        ST_SC_WR: if (xfer_done) begin
          poll_cnt <= '0;
          state    <= ST_SC_POLL;
        end
        ST_SC_POLL: if (xfer_done) begin
          if (!sc_busy) begin
            poll_cnt <= '0;
            state    <= ST_UP2;
          end else if (poll_cnt == SC_LAST) begin
            err_q    <= 1'b1;
            train_en <= 1'b0;
            state    <= ST_OV_RD;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_UP2: if (xfer_done) begin
          if (link_ok) begin
            state <= ST_LS_RD;
          end else if (poll_cnt == LINK_LAST) begin
            err_q    <= 1'b1;
            train_en <= 1'b0;
            state    <= ST_OV_RD;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_LS_RD: if (xfer_done) begin
          speed <= xfer_rdata[LS_SPD_LSB +: SPD_W];
          state <= ST_FIN;
        end
        ST_OV_RD: if (xfer_done) begin
          shadow <= xfer_rdata;
          state  <= ST_OV_SET;
        end
        ST_OV_SET: if (xfer_done) state <= ST_OV_HOLD;
        ST_OV_HOLD: if (hold_expired) state <= ST_OV_RD2;
        ST_OV_RD2: if (xfer_done) begin
          shadow <= xfer_rdata;
          state  <= ST_OV_CLR;
        end
        ST_OV_CLR: if (xfer_done) state <= ST_FIN;
        ST_FIN: begin
          done  <= 1'b1;
          fail  <= err_q;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
  import lss_pkg::*;
#(
  parameter int LINK_POLLS = 1000,
  parameter int SC_POLLS   = 200,
  parameter int HOLD_CYC   = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        max_gen,
  output logic              done,
  output logic              fail,
  output logic [SPD_W-1:0]  speed,
  output logic              train_en,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic              go;
  logic              go_we;
  reg_addr_e         go_addr;
  logic [DATA_W-1:0] go_wdata;
  logic              xfer_done;
  logic [DATA_W-1:0] xfer_rdata;
  logic              hold_load;
  logic              hold_expired;

  lss_ctrl_fsm #(
    .LINK_POLLS (LINK_POLLS),
    .SC_POLLS   (SC_POLLS)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .max_gen      (max_gen),
    .xfer_done    (xfer_done),
    .xfer_rdata   (xfer_rdata),
    .hold_expired (hold_expired),
    .go           (go),
    .go_we        (go_we),
    .go_addr      (go_addr),
    .go_wdata     (go_wdata),
    .hold_load    (hold_load),
    .done         (done),
    .fail         (fail),
    .speed        (speed),
    .train_en     (train_en)
  );

  lss_bus_port u_port (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .go_we      (go_we),
    .go_addr    (go_addr),
    .go_wdata   (go_wdata),
    .xfer_done  (xfer_done),
    .xfer_rdata (xfer_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata)
  );

  lss_hold_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (hold_load),
    .expired (hold_expired)
  );

endmodule

// File: rtl/lss_checker.sv
module lss_checker
  import lss_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              fail,
  input logic [SPD_W-1:0]  speed,
  input logic              train_en,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack
);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req);

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fail_only_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);

  assert_speed_zero_on_fail_R8: assert property (@(posedge clk) disable iff (rst)
    done && fail |-> speed == '0);

  assert_train_low_on_fail_R11: assert property (@(posedge clk) disable iff (rst)
    done && fail |-> !train_en);

  assert_no_req_at_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req);

endmodule

bind link_speed_seq lss_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .fail      (fail),
  .speed     (speed),
  .train_en  (train_en),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack)
);

// File: tb/sim_link_speed_seq.sv
`timescale 1ns/1ps
module sim_link_speed_seq;

  localparam int LINK_POLLS = 16;
  localparam int SC_POLLS   = 200;
  localparam int HOLD_CYC   = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  max_gen = 2'd1;
  logic        done, fail, train_en;
  logic [3:0]  speed;
  logic        bus_req, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  link_speed_seq #(
    .LINK_POLLS (LINK_POLLS),
    .SC_POLLS   (SC_POLLS),
    .HOLD_CYC   (HOLD_CYC)
  ) u0 (
    .clk (clk), .rst (rst), .start (start), .max_gen (max_gen),
    .done (done), .fail (fail), .speed (speed), .train_en (train_en),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_ack (bus_ack), .bus_rdata (bus_rdata)
  );

  // register model state and scenario knobs
  logic [31:0] cap_r, sctl_r, ovrd_r, lstat_r;
  int  dbg_reads, up_at, train_clear_at, sc_reads, sc_clear_after;
  bit  never_up, sc_never, drop_after_sc, sc_cleared;
  logic [31:0] cap_wr [4];
  int  cap_wr_n;
  logic [31:0] sctl_wr;
  int  sctl_wr_n;
  logic [31:0] ov_wr [4];
  int  ov_wr_n, ov_rd_n, ov_set_cyc, ov_rd2_cyc;
  bit  train_at_cap1;
  int  done_cnt, viol;
  logic prev_req, prev_ack, prev_we;
  logic [2:0] prev_addr;
  logic [31:0] prev_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        case (bus_addr)
          3'd0: begin
            cap_r <= bus_wdata;
            if (cap_wr_n < 4) cap_wr[cap_wr_n] <= bus_wdata;
            if (cap_wr_n == 0) train_at_cap1 <= train_en;
            cap_wr_n <= cap_wr_n + 1;
          end
          3'd1: begin
            sctl_r <= bus_wdata; sctl_wr <= bus_wdata;
            sctl_wr_n <= sctl_wr_n + 1; sc_reads <= 0;
          end
          3'd4: begin
            ovrd_r <= bus_wdata;
            if (ov_wr_n < 4) ov_wr[ov_wr_n] <= bus_wdata;
            if (ov_wr_n == 0) ov_set_cyc <= cyc;
            ov_wr_n <= ov_wr_n + 1;
          end
          default: ;
        endcase
      end else begin
        case (bus_addr)
          3'd0: bus_rdata <= cap_r;
          3'd1: begin
            sc_reads <= sc_reads + 1;
            if (sctl_r[17] && !sc_never && (sc_reads + 1 >= sc_clear_after)) begin
              sctl_r[17] <= 1'b0;
              bus_rdata  <= sctl_r & ~32'h0002_0000;
              sc_cleared <= 1'b1;
            end else begin
              bus_rdata <= sctl_r;
            end
          end
          3'd2: begin
            bus_rdata <= ({31'd0, (!never_up && dbg_reads >= up_at && !(drop_after_sc && sc_cleared))} << 4)
                       | ({31'd0, (dbg_reads < train_clear_at)} << 29);
            dbg_reads <= dbg_reads + 1;
          end
          3'd3: bus_rdata <= lstat_r;
          3'd4: begin
            bus_rdata <= ovrd_r;
            if (ov_rd_n == 1) ov_rd2_cyc <= cyc;
            ov_rd_n <= ov_rd_n + 1;
          end
          default: bus_rdata <= '0;
        endcase
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  // protocol and done monitor away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt <= done_cnt + 1;
      if (prev_req && !prev_ack &&
          (!bus_req || bus_addr != prev_addr || bus_wdata != prev_wdata || bus_we != prev_we))
        viol <= viol + 1;
    end
    prev_req <= bus_req; prev_ack <= bus_ack; prev_we <= bus_we;
    prev_addr <= bus_addr; prev_wdata <= bus_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic prep(input logic [31:0] cap0, input logic [31:0] sctl0,
                      input logic [31:0] ov0, input logic [3:0] spd);
    @(negedge clk);
    cap_r = cap0; sctl_r = sctl0; ovrd_r = ov0; lstat_r = 32'h0000_0000 | ({28'd0, spd} << 16);
    dbg_reads = 0; up_at = 2; train_clear_at = 0; never_up = 0;
    sc_reads = 0; sc_clear_after = 3; sc_never = 0; drop_after_sc = 0; sc_cleared = 0;
    cap_wr_n = 0; sctl_wr_n = 0; sctl_wr = '0; ov_wr_n = 0; ov_rd_n = 0;
    ov_set_cyc = 0; ov_rd2_cyc = 0; train_at_cap1 = 0; done_cnt = 0; viol = 0;
  endtask

  bit   r_fail;
  logic [3:0] r_speed;
  bit   r_train;

  task automatic run(input logic [1:0] g, input int extra_starts);
    int waited;
    @(negedge clk);
    max_gen = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < extra_starts; i++) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk); waited++;
    end
    r_fail = fail; r_speed = speed; r_train = train_en;
    chk(done === 1'b1, "R8", "done seen", {31'd0, done}, 32'd1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(done === 1'b0 && fail === 1'b0, "R1", "done/fail after reset", {30'd0, done, fail}, 32'd0);
    chk(speed === 4'd0, "R1", "speed after reset", {28'd0, speed}, 32'd0);
    chk(train_en === 1'b0 && bus_req === 1'b0, "R1", "train/req after reset",
        {30'd0, train_en, bus_req}, 32'd0);
  endtask

  task automatic t_gen1_ok();
    prep(32'hABCD_0003, 32'h0000_00F1, 32'h0, 4'd1);
    run(2'd1, 0);
    chk(cap_wr_n == 1, "R2", "cap write count", cap_wr_n, 1);
    chk(cap_wr[0] == 32'hABCD_0001, "R2", "gen1 cap value", cap_wr[0], 32'hABCD_0001);
    chk(train_at_cap1 == 1'b0, "R11", "train_en before cap write", {31'd0, train_at_cap1}, 0);
    chk(sctl_wr == 32'h0002_00F1, "R5", "speed change write", sctl_wr, 32'h0002_00F1);
    chk(r_fail == 1'b0, "R8", "fail on success", {31'd0, r_fail}, 0);
    chk(r_speed == 4'd1, "R6", "speed gen1", {28'd0, r_speed}, 1);
    chk(r_train == 1'b1, "R11", "train_en after success", {31'd0, r_train}, 1);
    chk(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
    chk(ov_wr_n == 0, "R7", "no override on success", ov_wr_n, 0);
  endtask

  task automatic t_gen2_ok();
    prep(32'h1234_567F, 32'h0, 32'h0, 4'd2);
    up_at = 5; train_clear_at = 8;
    run(2'd2, 0);
    chk(cap_wr_n == 2, "R4", "cap write count gen2", cap_wr_n, 2);
    chk(cap_wr[0] == 32'h1234_5671, "R2", "first cap value", cap_wr[0], 32'h1234_5671);
    chk(cap_wr[1] == 32'h1234_5672, "R4", "second cap value", cap_wr[1], 32'h1234_5672);
    chk(dbg_reads == 10, "R3", "debug reads with training bit", dbg_reads, 10);
    chk(r_fail == 1'b0 && r_speed == 4'd2, "R6", "gen2 result", {27'd0, r_fail, r_speed}, 32'd2);
  endtask

  task automatic t_gen_other();
    prep(32'h0000_0000, 32'h0, 32'h0, 4'd1);
    run(2'd3, 0);
    chk(cap_wr_n == 1 && cap_wr[0] == 32'h1, "R4", "max_gen 3 keeps gen1", cap_wr_n, 1);
  endtask

  task automatic t_link_timeout();
    int gap;
    prep(32'h0, 32'h0, 32'h0000_8001, 4'd1);
    never_up = 1;
    run(2'd1, 0);
    chk(dbg_reads == LINK_POLLS, "R3", "reads before link timeout", dbg_reads, LINK_POLLS);
    chk(r_fail == 1'b1, "R8", "fail on link timeout", {31'd0, r_fail}, 1);
    chk(r_speed == 4'd0, "R8", "speed on fail", {28'd0, r_speed}, 0);
    chk(r_train == 1'b0, "R11", "train_en on fail", {31'd0, r_train}, 0);
    chk(ov_wr_n == 2, "R7", "override writes", ov_wr_n, 2);
    chk(ov_wr[0] == 32'h0000_8029, "R7", "override set", ov_wr[0], 32'h0000_8029);
    chk(ov_wr[1] == 32'h0000_8001, "R7", "override clear", ov_wr[1], 32'h0000_8001);
    gap = ov_rd2_cyc - ov_set_cyc;
    chk(gap >= HOLD_CYC && gap <= HOLD_CYC + 8, "R7", "hold gap", gap, HOLD_CYC);
    chk(sctl_wr_n == 0, "R5", "no speed change after link fail", sctl_wr_n, 0);
  endtask

  task automatic t_sc_timeout();
    prep(32'h0, 32'h0000_0004, 32'hFFFF_FFD7, 4'd1);
    sc_never = 1;
    run(2'd1, 0);
    chk(sc_reads == SC_POLLS, "R5", "speed-change polls", sc_reads, SC_POLLS);
    chk(r_fail == 1'b1, "R5", "fail on speed-change timeout", {31'd0, r_fail}, 1);
    chk(ov_wr[0] == 32'hFFFF_FFFF && ov_wr[1] == 32'hFFFF_FFD7, "R7", "override bits only",
        ov_wr[1], 32'hFFFF_FFD7);
  endtask

  task automatic t_second_up_fail();
    prep(32'h0, 32'h0, 32'h0, 4'd2);
    drop_after_sc = 1;
    run(2'd1, 0);
    chk(r_fail == 1'b1, "R6", "fail when link lost after change", {31'd0, r_fail}, 1);
    chk(dbg_reads == 3 + LINK_POLLS, "R6", "second wait polls", dbg_reads, 3 + LINK_POLLS);
  endtask

  task automatic t_start_ignored();
    prep(32'h0, 32'h0, 32'h0, 4'd1);
    run(2'd1, 6);
    chk(cap_wr_n == 1, "R9", "restart during run ignored", cap_wr_n, 1);
    chk(done_cnt == 1, "R9", "single done", done_cnt, 1);
    prep(32'h0, 32'h0, 32'h0, 4'd3);
    run(2'd1, 0);
    chk(cap_wr_n == 1 && r_speed == 4'd3 && !r_fail, "R9", "new run after done",
        {28'd0, r_speed}, 3);
    chk(viol == 0, "R10", "bus request held until ack", viol, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gen1_ok();
    t_gen2_ok();
    t_gen_other();
    t_link_timeout();
    t_sc_timeout();
    t_second_up_fail();
    t_start_ignored();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule